// File: doc/BRIEF.md
# TCP Offload Engine Control Sequencer

This block is the bring-up and session controller that sits in front of a hardware TCP/IP offload engine. It owns the engine's register port and walks it through a fixed script. Once a debounced start button is seen, it loads the local network identity into eight configuration registers. It then takes the engine out of reset and polls the busy flag until initialisation finishes. After that it parks, waiting for a remote client to open a session, because the engine runs as a passive-open server.

When a session comes up, the mode-select input picks the direction. In transmit mode the sequencer programs the total transfer length and the per-packet length, then issues a send command. When the engine reports the transfer done, the sequencer issues a close command, so it closes the session actively. In receive mode it issues no writes and waits for the remote side to drop the session, which is a passive close. Both paths end back in the wait-for-open state, ready for the next client.

Register reads have one cycle of latency, and every write is a single-cycle write-enable pulse. The start input passes through a synchroniser and a counter-based debouncer before it is used.

Top module: `toe_ctrl_seq`

## Requirements
- R1: While rst_ni is low, reg_we_o is 0. After reset is released, no register is written until a start press is recognised.
- R2: A high level on start_btn_i is recognised only after it has held for DEB_CYC consecutive cycles once synchronised. A shorter pulse causes no register write.
- R3: A recognised press starts eight writes on eight consecutive cycles, to addresses 2 through 9 in that order, with these values:
  - address 2: 0x02030405 (low MAC bytes)
  - address 3: 0x00000001 (high MAC bytes)
  - address 4: 0xC0A80B2A (local IP)
  - address 5: 0xC0A80B19 (peer IP)
  - address 6: 4000 (local port)
  - address 7: DST_PORT
  - address 8: RETRY_TMO
  - address 9: 0 (passive open)
- R4: In the cycle after the last parameter write, the value 0 is written to the reset register at address 0.
- R5: Busy is bit 0 of the command register at address 1, and a read returns data one cycle after the address is presented. After the reset release, no write occurs until busy reads 0 and conn_on_i is 1.
- R6: When conn_on_i is 1 and mode_rx_i is 0 in the wait-for-open state, three writes follow on consecutive cycles: TX_LEN to address 10, PKT_LEN to address 11, and 0 (send) to address 1.
- R7: The close command, value 3 written to address 1, is issued only after busy has read 0 following the send command. Every write to address 1 is followed by a cycle with reg_we_o at 0.
- R8: After the close command, once busy reads 0, the sequencer returns to wait-for-open. If conn_on_i is already 1 by then, a new transmit sequence starts without any start press.
- R9: When conn_on_i is 1 and mode_rx_i is 1, no write is issued while conn_on_i stays 1. After conn_on_i falls to 0, the sequencer returns to wait-for-open.
- R10: Start presses after the first one recognised have no effect, and produce no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_btn_i | input | 1 | Raw start push-button level |
| mode_rx_i | input | 1 | 0 selects transmit, 1 selects receive |
| conn_on_i | input | 1 | Session-established status from the engine |
| reg_addr_o | output | 4 | Engine register address |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | 32 | Write data |
| reg_rdata_i | input | 32 | Read data, valid one cycle after the address; bit 0 of address 1 is busy |

## Verification
Two events can land in the same cycle: busy clearing at the end of the close poll, and a new client already holding conn_on_i high. The bench provokes this by keeping conn_on_i asserted through the whole close, so that the return to wait-for-open and the new session coincide. It then checks two things. First, a fresh length write must follow the close by no more than a few cycles beyond the busy window. Second, the write must not appear before busy has cleared.

// File: rtl/toe_seq_pkg.sv
package toe_seq_pkg;
  localparam int ADDR_W  = 4;
  localparam int REG_W   = 32;
  localparam int N_PARAM = 8;
  localparam int IDX_W   = $clog2(N_PARAM);

  localparam logic [ADDR_W-1:0] A_RST   = 4'd0;
  localparam logic [ADDR_W-1:0] A_CMD   = 4'd1;
  localparam logic [ADDR_W-1:0] A_PARAM = 4'd2;
  localparam logic [ADDR_W-1:0] A_TLEN  = 4'd10;
  localparam logic [ADDR_W-1:0] A_PLEN  = 4'd11;

  localparam logic [REG_W-1:0] CMD_SEND  = 32'd0;
  localparam logic [REG_W-1:0] CMD_CLOSE = 32'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PARAM, ST_CLR_RST, ST_WT_INIT, ST_WT_OPEN,
    ST_SET_TLEN, ST_SET_PLEN, ST_SEND, ST_WT_SEND,
    ST_CLOSE, ST_WT_CLOSE, ST_WT_REMOTE
  } seq_state_e;
endpackage

// File: rtl/start_debounce.sv
module start_debounce #(
  parameter int DEB_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic press_o
);
  localparam int CW = $clog2(DEB_CYC + 1);

  logic          s1_q, s2_q, lvl_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
      press_o <= 1'b0;
    end else begin
      s1_q    <= btn_i;
      s2_q    <= s1_q;
      press_o <= 1'b0;
      if (s2_q == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(DEB_CYC - 1)) begin
        cnt_q   <= '0;
        lvl_q   <= s2_q;
        press_o <= s2_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/toe_param_tbl.sv
module toe_param_tbl
  import toe_seq_pkg::*;
#(
  parameter logic [47:0] SRC_MAC   = 48'h00_01_02_03_04_05,
  parameter logic [31:0] SRC_IP    = 32'hC0A8_0B2A,
  parameter logic [31:0] DST_IP    = 32'hC0A8_0B19,
  parameter logic [15:0] SRC_PORT  = 16'd4000,
  parameter logic [15:0] DST_PORT  = 16'd0,
  parameter logic [31:0] RETRY_TMO = 32'd1000
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [REG_W-1:0]  data_o
);
  assign addr_o = A_PARAM + ADDR_W'(idx_i);

  always_comb begin
    unique case (idx_i)
      3'd0:    data_o = SRC_MAC[31:0];
      3'd1:    data_o = {16'd0, SRC_MAC[47:32]};
      3'd2:    data_o = SRC_IP;
      3'd3:    data_o = DST_IP;
      3'd4:    data_o = {16'd0, SRC_PORT};
      3'd5:    data_o = {16'd0, DST_PORT};
      3'd6:    data_o = RETRY_TMO;
      default: data_o = '0;  // passive open
    endcase
  end
endmodule

// File: rtl/toe_seq_fsm.sv
module toe_seq_fsm
  import toe_seq_pkg::*;
#(
  parameter logic [31:0] TX_LEN  = 32'd65536,
  parameter logic [31:0] PKT_LEN = 32'd1460
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              press_i,
  input  logic              conn_on_i,
  input  logic              mode_rx_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] par_addr_i,
  input  logic [REG_W-1:0]  par_data_i,
  output logic [IDX_W-1:0]  par_idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [REG_W-1:0]  wdata_o
);
  seq_state_e st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic poll_q;  // rdata reflects the command register this cycle
  logic is_poll, done;

  assign is_poll = (st_q == ST_WT_INIT) || (st_q == ST_WT_SEND) || (st_q == ST_WT_CLOSE);
  assign done    = poll_q && !busy_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:      if (press_i) st_d = ST_PARAM;
      ST_PARAM:     if (idx_q == IDX_W'(N_PARAM - 1)) st_d = ST_CLR_RST;
      ST_CLR_RST:   st_d = ST_WT_INIT;
      ST_WT_INIT:   if (done) st_d = ST_WT_OPEN;
      ST_WT_OPEN:   if (conn_on_i) st_d = mode_rx_i ? ST_WT_REMOTE : ST_SET_TLEN;
      ST_SET_TLEN:  st_d = ST_SET_PLEN;
      ST_SET_PLEN:  st_d = ST_SEND;
      ST_SEND:      st_d = ST_WT_SEND;
      ST_WT_SEND:   if (done) st_d = ST_CLOSE;
      ST_CLOSE:     st_d = ST_WT_CLOSE;
      ST_WT_CLOSE:  if (done) st_d = ST_WT_OPEN;
      ST_WT_REMOTE: if (!conn_on_i) st_d = ST_WT_OPEN;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      poll_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= (st_q == ST_PARAM) ? idx_q + 1'b1 : '0;
      poll_q <= is_poll && (st_d == st_q);
    end
  end

  assign par_idx_o = idx_q;

  always_comb begin
    we_o    = 1'b0;
    addr_o  = A_CMD;
    wdata_o = '0;
    unique case (st_q)
      ST_PARAM:    begin we_o = 1'b1; addr_o = par_addr_i; wdata_o = par_data_i; end
      ST_CLR_RST:  begin we_o = 1'b1; addr_o = A_RST;  wdata_o = '0;        end
      ST_SET_TLEN: begin we_o = 1'b1; addr_o = A_TLEN; wdata_o = TX_LEN;    end
      ST_SET_PLEN: begin we_o = 1'b1; addr_o = A_PLEN; wdata_o = PKT_LEN;   end
      ST_SEND:     begin we_o = 1'b1; addr_o = A_CMD;  wdata_o = CMD_SEND;  end
      ST_CLOSE:    begin we_o = 1'b1; addr_o = A_CMD;  wdata_o = CMD_CLOSE; end
      default:     ;
    endcase
  end
endmodule

// File: rtl/toe_ctrl_seq.sv
module toe_ctrl_seq
  import toe_seq_pkg::*;
#(
  parameter int          DEB_CYC   = 50000,
  parameter logic [31:0] TX_LEN    = 32'd65536,
  parameter logic [31:0] PKT_LEN   = 32'd1460,
  parameter logic [15:0] DST_PORT  = 16'd0,
  parameter logic [31:0] RETRY_TMO = 32'd1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_btn_i,
  input  logic        mode_rx_i,
  input  logic        conn_on_i,
  output logic [3:0]  reg_addr_o,
  output logic        reg_we_o,
  output logic [31:0] reg_wdata_o,
  input  logic [31:0] reg_rdata_i
);
  logic              press;
  logic [IDX_W-1:0]  par_idx;
  logic [ADDR_W-1:0] par_addr;
  logic [REG_W-1:0]  par_data;

  start_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .btn_i(start_btn_i), .press_o(press)
  );

  toe_param_tbl #(.DST_PORT(DST_PORT), .RETRY_TMO(RETRY_TMO)) u_tbl (
    .idx_i(par_idx), .addr_o(par_addr), .data_o(par_data)
  );

  toe_seq_fsm #(.TX_LEN(TX_LEN), .PKT_LEN(PKT_LEN)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .press_i(press),
    .conn_on_i(conn_on_i), .mode_rx_i(mode_rx_i), .busy_i(reg_rdata_i[0]),
    .par_addr_i(par_addr), .par_data_i(par_data), .par_idx_o(par_idx),
    .addr_o(reg_addr_o), .we_o(reg_we_o), .wdata_o(reg_wdata_o)
  );
endmodule

// File: rtl/toe_ctrl_seq_chk.sv
module toe_ctrl_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  reg_addr_o,
  input logic        reg_we_o,
  input logic [31:0] reg_wdata_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) a_r1_no_write_in_reset: assert (!reg_we_o);
  end

  a_r4_rst_after_params: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o && reg_addr_o == 4'd9 |=> reg_we_o && reg_addr_o == 4'd0 && reg_wdata_o == 32'd0);

  a_r6_plen_after_tlen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o && reg_addr_o == 4'd10 |=> reg_we_o && reg_addr_o == 4'd11);

  a_r6_send_after_plen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o && reg_addr_o == 4'd11 |=> reg_we_o && reg_addr_o == 4'd1 && reg_wdata_o == 32'd0);

  a_r7_quiet_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o && reg_addr_o == 4'd1 |=> !reg_we_o);
endmodule

bind toe_ctrl_seq toe_ctrl_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_o(reg_addr_o),
  .reg_we_o(reg_we_o), .reg_wdata_o(reg_wdata_o)
);

// File: tb/tb_toe_ctrl_seq.sv
`timescale 1ns/1ps
module tb_toe_ctrl_seq;
  localparam int DEB    = 4;
  localparam int INIT_C = 10;
  localparam int OP_C   = 20;
  localparam logic [31:0] TLEN = 32'd65536, PLEN = 32'd1460, RTMO = 32'd1000;

  logic clk = 0, rst_n = 0, start_btn = 0, mode_rx = 0, conn_on = 0;
  logic [3:0] addr; logic we; logic [31:0] wdata; logic [31:0] rdata;
  int n_chk = 0, n_fail = 0, n_wr = 0, cyc = 0, busy_cnt = 0;
  logic [3:0]  log_a [0:63];
  logic [31:0] log_d [0:63];
  int          log_c [0:63];
  logic        log_b [0:63];

  always #10 clk = ~clk;

  toe_ctrl_seq #(.DEB_CYC(DEB), .TX_LEN(TLEN), .PKT_LEN(PLEN), .RETRY_TMO(RTMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_btn_i(start_btn), .mode_rx_i(mode_rx),
    .conn_on_i(conn_on), .reg_addr_o(addr), .reg_we_o(we), .reg_wdata_o(wdata),
    .reg_rdata_i(rdata)
  );

  // engine register model with busy timer
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rdata <= (addr == 4'd1) ? {31'd0, busy_cnt != 0} : 32'd0;
    if (we && addr == 4'd1)      busy_cnt <= OP_C;
    else if (we && addr == 4'd0) busy_cnt <= INIT_C;
    else if (busy_cnt != 0)      busy_cnt <= busy_cnt - 1;
    if (rst_n && we && n_wr < 64) begin
      log_a[n_wr] <= addr; log_d[n_wr] <= wdata;
      log_c[n_wr] <= cyc;  log_b[n_wr] <= (busy_cnt != 0);
      n_wr <= n_wr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_par(int i);
    case (i)
      0: return 32'h0203_0405;  1: return 32'h0000_0001;
      2: return 32'hC0A8_0B2A;  3: return 32'hC0A8_0B19;
      4: return 32'd4000;       5: return 32'd0;
      6: return RTMO;           default: return 32'd0;
    endcase
  endfunction

  task automatic wait_wr(int n, int max);
    for (int i = 0; i < max && n_wr < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(we == 0, "R1", "we in reset", we, 0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk(n_wr == 0, "R1", "writes before start", n_wr, 0);
  endtask

  task automatic t_glitch;
    start_btn = 1; repeat (DEB - 1) @(negedge clk); start_btn = 0;
    repeat (20) @(negedge clk);
    chk(n_wr == 0, "R2", "short pulse writes", n_wr, 0);
  endtask

  task automatic t_init;
    start_btn = 1; repeat (DEB + 4) @(negedge clk); start_btn = 0;
    wait_wr(9, 60);
    chk(n_wr == 9, "R3", "init write count", n_wr, 9);
    for (int i = 0; i < 8; i++) begin
      chk(log_a[i] == 4'(i + 2), "R3", "param addr", log_a[i], i + 2);
      chk(log_d[i] == exp_par(i), "R3", "param data", log_d[i], exp_par(i));
      chk(log_c[i + 1] == log_c[i] + 1, "R3", "param spacing", log_c[i + 1] - log_c[i], 1);
    end
    chk(log_a[8] == 4'd0 && log_d[8] == 0, "R4", "reset release", {log_a[8], log_d[8][27:0]}, 0);
    repeat (INIT_C + 30) @(negedge clk);
    chk(n_wr == 9, "R5", "no write while waiting open", n_wr, 9);
  endtask

  task automatic check_tx(int b);
    chk(log_a[b] == 4'd10 && log_d[b] == TLEN, "R6", "total length", log_d[b], TLEN);
    chk(log_a[b+1] == 4'd11 && log_d[b+1] == PLEN, "R6", "packet length", log_d[b+1], PLEN);
    chk(log_a[b+2] == 4'd1 && log_d[b+2] == 0, "R6", "send cmd", log_d[b+2], 0);
    chk(log_c[b+2] == log_c[b] + 2, "R6", "tx spacing", log_c[b+2] - log_c[b], 2);
    chk(log_a[b+3] == 4'd1 && log_d[b+3] == 3, "R7", "close cmd", log_d[b+3], 3);
    chk(log_b[b+3] == 0 && log_c[b+3] - log_c[b+2] > OP_C, "R7", "close after busy",
        log_c[b+3] - log_c[b+2], OP_C + 1);
  endtask

  task automatic t_tx;
    int b = n_wr;
    mode_rx = 0; conn_on = 1;
    wait_wr(b + 4, 100);
    conn_on = 0;
    chk(n_wr == b + 4, "R6", "tx write count", n_wr, b + 4);
    check_tx(b);
    repeat (OP_C + 20) @(negedge clk);
    chk(n_wr == b + 4, "R8", "idle after close", n_wr, b + 4);
  endtask

  task automatic t_rx;
    int b = n_wr;
    mode_rx = 1; conn_on = 1;
    repeat (40) @(negedge clk);
    chk(n_wr == b, "R9", "rx writes", n_wr, b);
    conn_on = 0; @(negedge clk); @(negedge clk);
    mode_rx = 0; conn_on = 1;
    wait_wr(b + 4, 100);
    conn_on = 0;
    chk(n_wr == b + 4 && log_a[b] == 4'd10, "R9", "tx after remote close", n_wr, b + 4);
    repeat (OP_C + 10) @(negedge clk);
  endtask

  task automatic t_b2b;
    int b = n_wr;
    mode_rx = 0; conn_on = 1;
    wait_wr(b + 8, 200);
    conn_on = 0;
    chk(n_wr == b + 8, "R8", "back-to-back count", n_wr, b + 8);
    check_tx(b);
    check_tx(b + 4);
    chk(log_c[b+4] - log_c[b+3] > OP_C && log_c[b+4] - log_c[b+3] <= OP_C + 5, "R8",
        "restart gap", log_c[b+4] - log_c[b+3], OP_C + 3);
    repeat (OP_C + 10) @(negedge clk);
  endtask

  task automatic t_start_ignored;
    int b = n_wr;
    start_btn = 1; repeat (DEB + 4) @(negedge clk); start_btn = 0;
    repeat (30) @(negedge clk);
    chk(n_wr == b, "R10", "late start", n_wr, b);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_glitch();
    t_init();
    t_tx();
    t_rx();
    t_b2b();
    t_start_ignored();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule